// File: doc/BRIEF.md
# Multi-Block Program Page Buffer

This block collects program data for a flash array built from eight equal 32 KB blocks (256 KB in all). Every array block owns a 64-byte page latch. One program operation can therefore stage up to eight pages, 512 bytes in total. All staged pages must sit at one shared page offset inside their blocks. Bus writes are taken only during a program setup phase. The block records which array blocks received data and which offset is in use. When a start command arrives, it hands the staged pages, or an erase block mask, to a self-timed sequencer that lies outside this block.

Before any operation can begin, a fixed command sequence must run. First comes a setup command, then at least one bus write, then a start command. While the sequencer runs, the block raises busy and refuses array reads. It also ignores further commands and writes. When the sequencer reports done, the page latches return to the erased value 0xFF.

Top module: `pb_multi_page_buf`

## Requirements
- R1: A write address splits into array block = addr[17:15], page offset = addr[14:6] and byte index = addr[5:0]. An accepted write stores its byte in that block's latch at that byte index. The sequencer read port (`seq_rd_blk`, `seq_rd_byte`) returns the latch byte combinationally.
- R2: Latch contents change only for writes made in program setup. Writes in idle, in erase setup or while busy leave every latch unchanged. All latches hold 0xFF after reset.
- R3: The first accepted write in a program setup captures the page offset. A later write with a different offset is dropped, and `offset_err` rises from the next cycle. `offset_err` stays high until the next setup command is accepted, and that command clears it.
- R4: A write addressed to a block whose `lock_mask` bit is 1 is dropped. It does not set `offset_err`.
- R5: Command codes are 0 = abort, 1 = program setup, 2 = erase setup and 3 = start. A start is accepted in program setup when a write has been accepted and the written blocks minus locked blocks is non-zero. In the cycle after acceptance, `busy` = 1 and `seq_start` is high for exactly that one cycle. At the same time `seq_erase` = 0, `seq_blk_mask` = written blocks & ~`lock_mask`, and `seq_offset` = the captured offset.
- R6: In erase setup, at least one bus write (its data is discarded) must come before start. The start also needs `blk_sel` & ~`lock_mask` to be non-zero. If either condition fails, the start is ignored. An accepted erase start gives `seq_erase` = 1 and `seq_blk_mask` = `blk_sel` & ~`lock_mask`.
- R7: `busy` stays 1 until `seq_done` is sampled high. Commands given while busy have no effect.
- R8: `rd_grant` = `rd_req` while idle or in setup, and `rd_grant` = 0 while busy.
- R9: In the cycle after `seq_done` ends an operation, `busy` = 0 and every latch reads 0xFF.
- R10: An abort in either setup state returns the block to idle and sets every latch back to 0xFF. Setup commands are accepted only from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 abort, 1 program setup, 2 erase setup, 3 start |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 18 | Bus write byte address |
| wr_data | input | 8 | Bus write data |
| blk_sel | input | 8 | Blocks chosen for erase |
| lock_mask | input | 8 | Blocks protected from program and erase |
| rd_req | input | 1 | Array read request |
| rd_grant | output | 1 | Array read permitted |
| busy | output | 1 | Operation in progress |
| offset_err | output | 1 | Sticky flag for an offset mismatch |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_erase | output | 1 | 1 = erase, 0 = program |
| seq_blk_mask | output | 8 | Blocks the operation acts on |
| seq_offset | output | 9 | Shared page offset |
| seq_done | input | 1 | Sequencer completion |
| seq_rd_blk | input | 3 | Latch read: block |
| seq_rd_byte | input | 6 | Latch read: byte index |
| seq_rd_data | output | 8 | Latch read data |

## Verification
Registered results are due one clock edge after the edge that samples the stimulus. This covers latch contents, `offset_err`, `busy`, `seq_start`, `seq_blk_mask` and `seq_offset`. `rd_grant` and `seq_rd_data` are combinational and follow their inputs within the same cycle. The bench applies stimulus 1 ns after a rising edge and waits for the next rising edge. It then samples 1 ns later, which is exactly the cycle where the registered results first appear. Combinational reads are taken 1 ns after their select inputs change. Checks that a start was refused, or that a write was ignored, look at `busy` or at the latch through the sequencer read port in that same sampling slot.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PSET, ST_ESET, ST_BUSY} pb_state_t;
  typedef enum logic [1:0] {CMD_ABORT = 2'd0, CMD_PSETUP = 2'd1,
                            CMD_ESETUP = 2'd2, CMD_START = 2'd3} pb_cmd_t;

  // Extract a bit field of width w starting at lsb.
  function automatic int unsigned fld(input logic [31:0] a, input int lsb, input int w);
    return int'((a >> lsb) & ((32'd1 << w) - 32'd1));
  endfunction

  // Flat latch index for a block and byte.
  function automatic int unsigned lat_idx(input int unsigned blk, input int unsigned byt,
                                          input int unsigned page_bytes);
    return blk * page_bytes + byt;
  endfunction
endpackage

// File: rtl/pb_latch.sv
module pb_latch #(
  parameter int NB = 8,
  parameter int PB = 64,
  parameter int DW = 8,
  localparam int BW = $clog2(NB),
  localparam int YW = $clog2(PB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] wblk,
  input  logic [YW-1:0] wbyte,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic [BW-1:0] rblk,
  input  logic [YW-1:0] rbyte,
  output logic [DW-1:0] rdata
);
  import pb_pkg::*;
  localparam int DEPTH = NB * PB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[lat_idx(32'(wblk), 32'(wbyte), PB)] <= wdata;
    end
  end

  assign rdata = mem[lat_idx(32'(rblk), 32'(rbyte), PB)];
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl #(
  parameter int NB = 8,
  parameter int OW = 9,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [OW-1:0] wr_off,
  input  logic [NB-1:0] blk_sel,
  input  logic [NB-1:0] lock_mask,
  input  logic          seq_done,
  output logic          busy,
  output logic          seq_start,
  output logic          seq_erase,
  output logic [NB-1:0] seq_blk_mask,
  output logic [OW-1:0] seq_offset,
  output logic          offset_err,
  output logic          latch_we,
  output logic          latch_clr,
  output logic          ev_off_mismatch,
  output logic          ev_start,
  output logic          ev_setup
);
  import pb_pkg::*;

  pb_state_t     st;
  logic          have_wr;
  logic [NB-1:0] written;
  logic [NB-1:0] start_mask;
  logic          blk_locked, start_ok, ev_abort, ev_finish, ev_iwrite;
  logic          is_cmd_start;

  assign blk_locked      = lock_mask[wr_blk];
  assign latch_we        = (st == ST_PSET) && wr_en && !blk_locked &&
                           (!have_wr || wr_off == seq_offset);
  assign ev_off_mismatch = (st == ST_PSET) && wr_en && !blk_locked &&
                           have_wr && (wr_off != seq_offset);
  assign ev_iwrite       = (st == ST_ESET) && wr_en;
  assign start_mask      = (st == ST_ESET) ? (blk_sel & ~lock_mask) : (written & ~lock_mask);
  assign start_ok        = have_wr && (start_mask != '0);
  assign is_cmd_start    = cmd_valid && (cmd_code == CMD_START);
  assign ev_start        = is_cmd_start && (st == ST_PSET || st == ST_ESET) && start_ok;
  assign ev_abort        = cmd_valid && (cmd_code == CMD_ABORT) &&
                           (st == ST_PSET || st == ST_ESET);
  assign ev_setup        = cmd_valid && (st == ST_IDLE) &&
                           (cmd_code == CMD_PSETUP || cmd_code == CMD_ESETUP);
  assign ev_finish       = (st == ST_BUSY) && seq_done;
  assign latch_clr       = ev_abort || ev_finish;
  assign busy            = (st == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      have_wr      <= 1'b0;
      written      <= '0;
      seq_offset   <= '0;
      seq_start    <= 1'b0;
      seq_erase    <= 1'b0;
      seq_blk_mask <= '0;
      offset_err   <= 1'b0;
    end else begin
      seq_start <= ev_start;
      if (ev_setup) begin
        st         <= (cmd_code == CMD_PSETUP) ? ST_PSET : ST_ESET;
        have_wr    <= 1'b0;
        written    <= '0;
        offset_err <= 1'b0;
      end
      if (latch_we) begin
        have_wr         <= 1'b1;
        seq_offset      <= wr_off;
        written[wr_blk] <= 1'b1;
      end
      if (ev_iwrite) have_wr <= 1'b1;
      if (ev_off_mismatch) offset_err <= 1'b1;
      if (ev_start) begin
        st           <= ST_BUSY;
        seq_erase    <= (st == ST_ESET);
        seq_blk_mask <= start_mask;
      end
      if (ev_abort || ev_finish) begin
        st      <= ST_IDLE;
        have_wr <= 1'b0;
        written <= '0;
      end
    end
  end
endmodule

// File: rtl/pb_multi_page_buf.sv
module pb_multi_page_buf #(
  parameter int NUM_BLK    = 8,
  parameter int BLK_BYTES  = 32768,
  parameter int PAGE_BYTES = 64,
  parameter int DW         = 8,
  localparam int BW = $clog2(NUM_BLK),
  localparam int YW = $clog2(PAGE_BYTES),
  localparam int OW = $clog2(BLK_BYTES) - YW,
  localparam int AW = $clog2(BLK_BYTES) + BW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_code,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [NUM_BLK-1:0] blk_sel,
  input  logic [NUM_BLK-1:0] lock_mask,
  input  logic               rd_req,
  output logic               rd_grant,
  output logic               busy,
  output logic               offset_err,
  output logic               seq_start,
  output logic               seq_erase,
  output logic [NUM_BLK-1:0] seq_blk_mask,
  output logic [OW-1:0]      seq_offset,
  input  logic               seq_done,
  input  logic [BW-1:0]      seq_rd_blk,
  input  logic [YW-1:0]      seq_rd_byte,
  output logic [DW-1:0]      seq_rd_data
);
  import pb_pkg::*;

  logic [BW-1:0] wr_blk;
  logic [OW-1:0] wr_off;
  logic [YW-1:0] wr_byte;
  logic          latch_we, latch_clr;
  logic          ev_off_mismatch, ev_start, ev_setup;

  assign wr_byte  = YW'(fld(32'(wr_addr), 0, YW));
  assign wr_off   = OW'(fld(32'(wr_addr), YW, OW));
  assign wr_blk   = BW'(fld(32'(wr_addr), YW + OW, BW));
  assign rd_grant = rd_req && !busy;

  pb_ctrl #(.NB(NUM_BLK), .OW(OW)) u_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_code, .wr_en, .wr_blk, .wr_off,
    .blk_sel, .lock_mask, .seq_done, .busy, .seq_start, .seq_erase,
    .seq_blk_mask, .seq_offset, .offset_err, .latch_we, .latch_clr,
    .ev_off_mismatch, .ev_start, .ev_setup
  );

  pb_latch #(.NB(NUM_BLK), .PB(PAGE_BYTES), .DW(DW)) u_latch (
    .clk, .rst_n, .we(latch_we), .wblk(wr_blk), .wbyte(wr_byte),
    .wdata(wr_data), .clr(latch_clr), .rblk(seq_rd_blk),
    .rbyte(seq_rd_byte), .rdata(seq_rd_data)
  );
endmodule

// File: rtl/pb_multi_page_buf_chk.sv
module pb_multi_page_buf_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          seq_done,
  input logic          seq_start,
  input logic [NB-1:0] seq_blk_mask,
  input logic [NB-1:0] lock_mask,
  input logic          rd_grant,
  input logic          offset_err,
  input logic          ev_off_mismatch,
  input logic          ev_setup,
  input logic          ev_start
);
  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off_mismatch |=> offset_err);
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_err && !ev_setup) |=> offset_err);
  assert_mask_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> ((seq_blk_mask & $past(lock_mask)) == '0));
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (busy && seq_start));
  assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (seq_blk_mask != '0));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);
  assert_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_grant);
  assert_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(seq_done));
endmodule

bind pb_multi_page_buf pb_multi_page_buf_chk #(.NB(NUM_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .seq_done(seq_done),
  .seq_start(seq_start), .seq_blk_mask(seq_blk_mask), .lock_mask(lock_mask),
  .rd_grant(rd_grant), .offset_err(offset_err),
  .ev_off_mismatch(ev_off_mismatch), .ev_setup(ev_setup), .ev_start(ev_start)
);

// File: tb/pb_multi_page_buf_test.sv
module pb_multi_page_buf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic wr_en = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] blk_sel = '0;
  logic [7:0] lock_mask = '0;
  logic rd_req = 1'b0;
  logic rd_grant, busy, offset_err, seq_start, seq_erase;
  logic [7:0] seq_blk_mask;
  logic [8:0] seq_offset;
  logic seq_done = 1'b0;
  logic [2:0] seq_rd_blk = '0;
  logic [5:0] seq_rd_byte = '0;
  logic [7:0] seq_rd_data;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pb_multi_page_buf uut (.*);

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [1:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic bwrite(input int blk, input int off, input int byt, input logic [7:0] d);
    wr_en = 1'b1;
    wr_addr = 18'((blk << 15) | (off << 6) | byt);
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic peek(input int blk, input int byt, output logic [7:0] d);
    seq_rd_blk = 3'(blk); seq_rd_byte = 6'(byt);
    #1 d = seq_rd_data;
  endtask

  task automatic finish_op();
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R2 reset busy", busy, 0);
    chk("R3 reset err", offset_err, 0);
    rd_req = 1'b1; #1;
    chk("R8 grant idle", rd_grant, 1);
    rd_req = 1'b0;
    peek(0, 0, d); chk("R2 reset latch", d, 8'hFF);
    peek(7, 63, d); chk("R2 reset latch top", d, 8'hFF);
  endtask

  task automatic t_idle_write();
    logic [7:0] d;
    bwrite(2, 5, 3, 8'h5A);
    peek(2, 3, d); chk("R2 idle write ignored", d, 8'hFF);
    cmd(2'd3);
    chk("R7 start in idle ignored", busy, 0);
  endtask

  task automatic t_program();
    logic [7:0] d;
    cmd(2'd1);
    bwrite(1, 16, 0, 8'h11);
    bwrite(4, 16, 63, 8'h44);
    bwrite(7, 16, 7, 8'h77);
    peek(1, 0, d);  chk("R1 blk1 byte0", d, 8'h11);
    peek(4, 63, d); chk("R1 blk4 byte63", d, 8'h44);
    peek(7, 7, d);  chk("R1 blk7 byte7", d, 8'h77);
    chk("R3 no err yet", offset_err, 0);
    bwrite(2, 17, 0, 8'h22);
    chk("R3 mismatch err", offset_err, 1);
    peek(2, 0, d); chk("R3 mismatch dropped", d, 8'hFF);
    lock_mask = 8'h08;
    bwrite(3, 16, 1, 8'h33);
    peek(3, 1, d); chk("R4 locked dropped", d, 8'hFF);
    cmd(2'd3);
    chk("R5 busy", busy, 1);
    chk("R5 start pulse", seq_start, 1);
    chk("R5 program kind", seq_erase, 0);
    chk("R5 mask", seq_blk_mask, 8'h92);
    chk("R5 offset", seq_offset, 16);
    tick();
    chk("R5 pulse one cycle", seq_start, 0);
    rd_req = 1'b1; #1;
    chk("R8 grant blocked", rd_grant, 0);
    bwrite(1, 16, 1, 8'hAB);
    peek(1, 1, d); chk("R7 busy write ignored", d, 8'hFF);
    cmd(2'd0);
    chk("R7 abort ignored busy", busy, 1);
    peek(1, 0, d); chk("R7 latch kept busy", d, 8'h11);
    repeat (5) tick();
    chk("R7 busy held", busy, 1);
    finish_op();
    chk("R9 busy cleared", busy, 0);
    chk("R8 grant back", rd_grant, 1);
    rd_req = 1'b0;
    peek(1, 0, d);  chk("R9 latch cleared", d, 8'hFF);
    peek(7, 7, d);  chk("R9 latch cleared b7", d, 8'hFF);
    lock_mask = 8'h00;
  endtask

  task automatic t_setup_abort();
    logic [7:0] d;
    chk("R3 err sticky idle", offset_err, 1);
    cmd(2'd1);
    chk("R3 err cleared on setup", offset_err, 0);
    bwrite(5, 3, 9, 8'h55);
    lock_mask = 8'h20;
    cmd(2'd3);
    chk("R5 start empty mask ignored", busy, 0);
    lock_mask = 8'h00;
    cmd(2'd0);
    peek(5, 9, d); chk("R10 abort clears latch", d, 8'hFF);
    cmd(2'd3);
    chk("R10 idle after abort", busy, 0);
    bwrite(5, 3, 9, 8'h56);
    peek(5, 9, d); chk("R10 idle write ignored", d, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] d;
    blk_sel = 8'h0F; lock_mask = 8'h02;
    cmd(2'd2);
    cmd(2'd3);
    chk("R6 start without write ignored", busy, 0);
    bwrite(0, 0, 0, 8'h00);
    peek(0, 0, d); chk("R2 erase write no latch", d, 8'hFF);
    cmd(2'd1);
    chk("R10 setup ignored in setup", busy, 0);
    cmd(2'd3);
    chk("R6 erase busy", busy, 1);
    chk("R6 erase kind", seq_erase, 1);
    chk("R6 erase mask", seq_blk_mask, 8'h0D);
    tick();
    finish_op();
    chk("R9 erase done", busy, 0);
    blk_sel = 8'h00; lock_mask = 8'h00;
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_idle_write();
    t_program();
    t_setup_abort();
    t_erase();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule